// File: doc/BRIEF.md
# High-Speed Data Lane Transmit Sequencer

This block sequences the transmit side of a set of display PHY data lanes. For every lane it steps between the low-power stop condition and high-speed transmission. It sends a request pattern, a bridge pattern, a zero preamble, the payload bytes and a trailer, and then returns to low-power stop. Each of these phases lasts a programmable number of lane byte clocks.

A link layer raises one shared high-speed request and presents one parallel byte per lane. A register block supplies the phase counts, the bit-order choice, a force-stop control, per-lane override selects and values for the two analog enables, and a per-lane power-down mask. The outputs drive the analog lane enables, the two low-power line levels, a byte that is already in serialization order, and a status nibble for each lane. Everything runs on the lane byte clock.

Top module: `hs_lane_tx_sequencer`

## Requirements
- R1: After a synchronous active-low reset, and after a reset applied during a burst, every powered lane sits in stop. In stop, lp_p=1, lp_n=1, tx_lp_en=1, tx_hs_en=0, hs_byte=0 and status=4'b0100.
- R2: When the request is sampled high in stop, the lane first drives LP-01 (lp_p=0, lp_n=1, tx_lp_en=1) for max(req_cnt,1) cycles. It then drives LP-00 with tx_lp_en=1 and tx_hs_en=0 for max(hs_timing[31:24],1) cycles.
- R3: The zero preamble lasts max(hs_timing[23:16],1) cycles with tx_hs_en=1, tx_lp_en=0, hs_byte=8'h00 and status=4'b0001.
- R4: In the payload phase, hs_byte carries the lane's input byte. Bit 0 of hs_byte is sent first. With msb_first=1 the byte is bit-reversed, so hs_byte[0]=byte_in[7]. With msb_first=0 it is passed unchanged. The phase lasts while the request stays high.
- R5: Once the request is sampled low in the payload phase, the trailer lasts max(hs_timing[15:8],1) cycles. In the trailer every bit of hs_byte equals the complement of hs_byte[7] of the last payload byte. The lane then drives LP-11 for max(hs_timing[7:0],1) cycles with status 4'b0100, ignoring the request, and then returns to stop.
- R6: While force_stop is 1, every lane enters stop at the next clock and stays there whatever the request. After force_stop is released, a held request starts a new sequence.
- R7: When a lane's select bit for tx_hs_en or tx_lp_en is 1, that output equals the matching value bit. The lane's status and its phase sequence are unaffected.
- R8: A powered-down lane drives 0 on tx_hs_en, tx_lp_en, lp_p, lp_n, hs_byte and status, and its sequencer is held in stop. When power-down is released, the lane resumes from stop.
- R9: A phase count of zero yields a phase of exactly one cycle.
- R10: Lanes are independent. Powering one lane down does not alter the sequence of the others, and each lane sends its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_req | input | 1 | High-speed request shared by all lanes |
| byte_in | input | NUM_LANES*BYTE_W | Payload byte per lane, lane i at [i*BYTE_W +: BYTE_W] |
| req_cnt | input | CNT_W | LP-01 request duration in byte clocks |
| hs_timing | input | 4*CNT_W | {bridge, zero, trailer, exit} counts |
| msb_first | input | 1 | 1: byte sent MSB first, 0: LSB first |
| force_stop | input | 1 | Holds every lane in stop |
| lane_pd | input | NUM_LANES | Per-lane power-down |
| ovr_hs_sel | input | NUM_LANES | Select register value for tx_hs_en |
| ovr_hs_val | input | NUM_LANES | Register value for tx_hs_en |
| ovr_lp_sel | input | NUM_LANES | Select register value for tx_lp_en |
| ovr_lp_val | input | NUM_LANES | Register value for tx_lp_en |
| tx_hs_en | output | NUM_LANES | High-speed driver enable per lane |
| tx_lp_en | output | NUM_LANES | Low-power driver enable per lane |
| lp_p | output | NUM_LANES | Low-power level, positive line |
| lp_n | output | NUM_LANES | Low-power level, negative line |
| hs_byte | output | NUM_LANES*BYTE_W | Byte in serialization order, bit 0 first |
| lane_status | output | NUM_LANES*4 | {0, stop, ulps (0), hs_active} per lane |

## Verification
Two pairs of functions can act in the same cycle. In the first, force_stop arrives while a lane is in its payload phase with the request still high. The bench judges that the stop wins on the next edge, that it holds, and that a request is accepted only after release. In the second, a register override of tx_hs_en is applied mid-payload. The bench checks that the enable follows the register while the status still reports high-speed activity, so the override and the sequencer are seen to be separate.

// File: rtl/hs_lane_pkg.sv
// Package: types shared by the lane sequencer and lane output stage.
// Assumes: one phase encoding is used by every lane.
package hs_lane_pkg;
    typedef enum logic [2:0] {
        PH_STOP   = 3'd0,
        PH_REQ    = 3'd1,
        PH_BRIDGE = 3'd2,
        PH_ZERO   = 3'd3,
        PH_DATA   = 3'd4,
        PH_TRAIL  = 3'd5,
        PH_EXIT   = 3'd6
    } phase_t;
endpackage

// File: rtl/hs_lane_seq.sv
// Module: per-lane phase sequencer. It walks stop, request, bridge, zero,
// payload, trailer and exit, timing each phase with a down counter.
// Assumes: a count of zero means one cycle, and force_stop and power_down
// override the request.
module hs_lane_seq
    import hs_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_req,
    input  logic             force_stop,
    input  logic             power_down,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic [CNT_W-1:0] bridge_cnt,
    input  logic [CNT_W-1:0] zero_cnt,
    input  logic [CNT_W-1:0] trail_cnt,
    input  logic [CNT_W-1:0] exit_cnt,
    output phase_t           phase,
    output logic             fsm_hs_en,
    output logic             fsm_lp_en,
    output logic             fsm_lp_p,
    output logic             fsm_lp_n
);
    logic [CNT_W-1:0] remain;
    logic             last;

    // Load value for a phase: its count minus one, with zero treated as one.
    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    assign last = (remain == '0);

    // Phase register and down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_STOP;
            remain <= '0;
        end else if (power_down || force_stop) begin
            phase  <= PH_STOP;
            remain <= '0;
        end else begin
            case (phase)
                PH_STOP: if (hs_req) begin
                    phase  <= PH_REQ;
                    remain <= load_of(req_cnt);
                end
                PH_REQ: if (last) begin
                    phase  <= PH_BRIDGE;
                    remain <= load_of(bridge_cnt);
                end else remain <= remain - 1'b1;
                PH_BRIDGE: if (last) begin
                    phase  <= PH_ZERO;
                    remain <= load_of(zero_cnt);
                end else remain <= remain - 1'b1;
                PH_ZERO: if (last) begin
                    phase  <= PH_DATA;
                    remain <= '0;
                end else remain <= remain - 1'b1;
                PH_DATA: if (!hs_req) begin
                    phase  <= PH_TRAIL;
                    remain <= load_of(trail_cnt);
                end
                PH_TRAIL: if (last) begin
                    phase  <= PH_EXIT;
                    remain <= load_of(exit_cnt);
                end else remain <= remain - 1'b1;
                PH_EXIT: if (last) begin
                    phase  <= PH_STOP;
                    remain <= '0;
                end else remain <= remain - 1'b1;
                default: begin
                    phase  <= PH_STOP;
                    remain <= '0;
                end
            endcase
        end
    end

    // Line pattern decode for each phase.
    always_comb begin
        fsm_hs_en = phase inside {PH_ZERO, PH_DATA, PH_TRAIL};
        fsm_lp_en = phase inside {PH_STOP, PH_REQ, PH_BRIDGE, PH_EXIT};
        fsm_lp_p  = phase inside {PH_STOP, PH_EXIT};
        fsm_lp_n  = phase inside {PH_STOP, PH_REQ, PH_EXIT};
    end

    AST_BRIDGE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BRIDGE && $past(phase) != PH_BRIDGE) |-> $past(phase) == PH_REQ); // R2
    AST_ZERO_FROM_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ZERO && $past(phase) != PH_ZERO) |-> $past(phase) == PH_BRIDGE); // R3
    AST_DATA_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_ZERO); // R4
    AST_EXIT_FROM_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXIT && $past(phase) != PH_EXIT) |-> $past(phase) == PH_TRAIL); // R5
    AST_FORCE_HOLDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> phase == PH_STOP); // R6
    AST_PD_HOLDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> phase == PH_STOP); // R8
endmodule

// File: rtl/hs_lane_out.sv
// Module: per-lane output stage. It applies the bit order, the trailer fill,
// the register overrides and the power-down gating, and builds the status nibble.
// Assumes: hs_byte bit 0 leaves the serializer first.
module hs_lane_out
    import hs_lane_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              fsm_hs_en,
    input  logic              fsm_lp_en,
    input  logic              fsm_lp_p,
    input  logic              fsm_lp_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              msb_first,
    input  logic              power_down,
    input  logic              hs_sel,
    input  logic              hs_val,
    input  logic              lp_sel,
    input  logic              lp_val,
    output logic              tx_hs_en,
    output logic              tx_lp_en,
    output logic              lp_p,
    output logic              lp_n,
    output logic [BYTE_W-1:0] hs_byte,
    output logic [3:0]        status
);
    logic [BYTE_W-1:0] reversed;
    logic [BYTE_W-1:0] ordered;
    logic              last_bit;

    // Bit reversal wiring for MSB-first order.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
        assign reversed[b] = byte_in[BYTE_W-1-b];
    end

    assign ordered = msb_first ? reversed : byte_in;

    // Remember the final serialized bit of each payload byte for the trailer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_bit <= 1'b0;
        else if (phase == PH_DATA)  last_bit <= ordered[BYTE_W-1];
    end

    // Output selection, overrides and power-down gating.
    always_comb begin
        tx_hs_en = 1'b0;
        tx_lp_en = 1'b0;
        lp_p     = 1'b0;
        lp_n     = 1'b0;
        hs_byte  = '0;
        status   = 4'b0000;
        if (!power_down) begin
            tx_hs_en = hs_sel ? hs_val : fsm_hs_en;
            tx_lp_en = lp_sel ? lp_val : fsm_lp_en;
            lp_p     = fsm_lp_p;
            lp_n     = fsm_lp_n;
            if (phase == PH_DATA)       hs_byte = ordered;
            else if (phase == PH_TRAIL) hs_byte = {BYTE_W{~last_bit}};
            status   = {1'b0, fsm_lp_p & fsm_lp_n, 1'b0, fsm_hs_en};
        end
    end

    AST_TRAIL_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRAIL && !power_down) |->
            ($countones(hs_byte) == 0 || $countones(hs_byte) == BYTE_W)); // R5
    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_sel && !lp_sel) |-> !(tx_hs_en && tx_lp_en)); // R3
    AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (status == 4'b0000 && hs_byte == '0)); // R8
endmodule

// File: rtl/hs_lane_tx_sequencer.sv
// Module: top level. It instantiates one sequencer and one output stage per
// data lane and splits the shared timing word into its phase counts.
// Assumes: all lanes share the request, the timing, the bit order and force-stop.
module hs_lane_tx_sequencer
    import hs_lane_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int BYTE_W    = 8,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hs_req,
    input  logic [NUM_LANES*BYTE_W-1:0] byte_in,
    input  logic [CNT_W-1:0]            req_cnt,
    input  logic [4*CNT_W-1:0]          hs_timing,
    input  logic                        msb_first,
    input  logic                        force_stop,
    input  logic [NUM_LANES-1:0]        lane_pd,
    input  logic [NUM_LANES-1:0]        ovr_hs_sel,
    input  logic [NUM_LANES-1:0]        ovr_hs_val,
    input  logic [NUM_LANES-1:0]        ovr_lp_sel,
    input  logic [NUM_LANES-1:0]        ovr_lp_val,
    output logic [NUM_LANES-1:0]        tx_hs_en,
    output logic [NUM_LANES-1:0]        tx_lp_en,
    output logic [NUM_LANES-1:0]        lp_p,
    output logic [NUM_LANES-1:0]        lp_n,
    output logic [NUM_LANES*BYTE_W-1:0] hs_byte,
    output logic [NUM_LANES*4-1:0]      lane_status
);
    localparam int BRIDGE_LSB = 3 * CNT_W;
    localparam int ZERO_LSB   = 2 * CNT_W;
    localparam int TRAIL_LSB  = CNT_W;
    localparam int EXIT_LSB   = 0;

    logic [CNT_W-1:0] bridge_cnt, zero_cnt, trail_cnt, exit_cnt;

    assign bridge_cnt = hs_timing[BRIDGE_LSB +: CNT_W];
    assign zero_cnt   = hs_timing[ZERO_LSB   +: CNT_W];
    assign trail_cnt  = hs_timing[TRAIL_LSB  +: CNT_W];
    assign exit_cnt   = hs_timing[EXIT_LSB   +: CNT_W];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        phase_t phase;
        logic   f_hs, f_lp, f_p, f_n;

        hs_lane_seq #(.CNT_W(CNT_W)) i_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .hs_req     (hs_req),
            .force_stop (force_stop),
            .power_down (lane_pd[i]),
            .req_cnt    (req_cnt),
            .bridge_cnt (bridge_cnt),
            .zero_cnt   (zero_cnt),
            .trail_cnt  (trail_cnt),
            .exit_cnt   (exit_cnt),
            .phase      (phase),
            .fsm_hs_en  (f_hs),
            .fsm_lp_en  (f_lp),
            .fsm_lp_p   (f_p),
            .fsm_lp_n   (f_n)
        );

        hs_lane_out #(.BYTE_W(BYTE_W)) i_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .phase      (phase),
            .fsm_hs_en  (f_hs),
            .fsm_lp_en  (f_lp),
            .fsm_lp_p   (f_p),
            .fsm_lp_n   (f_n),
            .byte_in    (byte_in[i*BYTE_W +: BYTE_W]),
            .msb_first  (msb_first),
            .power_down (lane_pd[i]),
            .hs_sel     (ovr_hs_sel[i]),
            .hs_val     (ovr_hs_val[i]),
            .lp_sel     (ovr_lp_sel[i]),
            .lp_val     (ovr_lp_val[i]),
            .tx_hs_en   (tx_hs_en[i]),
            .tx_lp_en   (tx_lp_en[i]),
            .lp_p       (lp_p[i]),
            .lp_n       (lp_n[i]),
            .hs_byte    (hs_byte[i*BYTE_W +: BYTE_W]),
            .status     (lane_status[i*4 +: 4])
        );
    end
endmodule

// File: tb/test_hs_lane_tx_sequencer.sv
module test_hs_lane_tx_sequencer;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hs_req = 1'b0;
    logic [NL*8-1:0] byte_in = '0;
    logic [7:0]    req_cnt = 8'd1;
    logic [31:0]   hs_timing = 32'h01010101;
    logic          msb_first = 1'b0;
    logic          force_stop = 1'b0;
    logic [NL-1:0] lane_pd = '0;
    logic [NL-1:0] ovr_hs_sel = '0, ovr_hs_val = '0, ovr_lp_sel = '0, ovr_lp_val = '0;
    logic [NL-1:0] tx_hs_en, tx_lp_en, lp_p, lp_n;
    logic [NL*8-1:0] hs_byte;
    logic [NL*4-1:0] lane_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hs_lane_tx_sequencer i_hs_lane_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .byte_in(byte_in),
        .req_cnt(req_cnt), .hs_timing(hs_timing), .msb_first(msb_first),
        .force_stop(force_stop), .lane_pd(lane_pd),
        .ovr_hs_sel(ovr_hs_sel), .ovr_hs_val(ovr_hs_val),
        .ovr_lp_sel(ovr_lp_sel), .ovr_lp_val(ovr_lp_val),
        .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .lp_p(lp_p), .lp_n(lp_n),
        .hs_byte(hs_byte), .lane_status(lane_status)
    );

    // Timing sets: {req, bridge, zero, trail, exit, msb_first}
    localparam logic [40:0] CFG_TAB [4] = '{
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0},
        {8'd1, 8'd2, 8'd3, 8'd2, 8'd1, 1'b1},
        {8'd3, 8'd1, 8'd1, 8'd1, 8'd4, 1'b0},
        {8'd2, 8'd5, 8'd2, 8'd3, 8'd2, 1'b1}
    };

    function automatic int eff(input logic [7:0] f);
        return (f == 8'd0) ? 1 : int'(f);
    endfunction

    function automatic logic [7:0] order(input logic [7:0] b, input logic m);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return m ? r : b;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected value packed as {hs_en, lp_en, p, n, byte, status}.
    task automatic chk_lane(input string tag, input int l, input logic hs, input logic lp,
                            input logic p, input logic n, input logic [7:0] b,
                            input logic [3:0] st);
        chk(tag, {16'd0, tx_hs_en[l], tx_lp_en[l], lp_p[l], lp_n[l],
                  hs_byte[l*8 +: 8], lane_status[l*4 +: 4]},
                 {16'd0, hs, lp, p, n, b, st});
    endtask

    task automatic chk_all_stop(input string tag);
        for (int l = 0; l < NL; l++) chk_lane(tag, l, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'b0100);
    endtask

    task automatic run_burst(input logic [40:0] c);
        logic [7:0] lastb [NL];
        req_cnt   = c[40:33];
        hs_timing = c[32:1];
        msb_first = c[0];
        hs_req = 1'b1;
        tick();
        repeat (eff(c[40:33]))
            begin for (int l = 0; l < NL; l++) chk_lane("R2/R9 request", l, 0, 1, 0, 1, 8'h00, 4'b0000); tick(); end
        repeat (eff(c[32:25]))
            begin for (int l = 0; l < NL; l++) chk_lane("R2/R9 bridge", l, 0, 1, 0, 0, 8'h00, 4'b0000); tick(); end
        repeat (eff(c[24:17]))
            begin for (int l = 0; l < NL; l++) chk_lane("R3/R9 zero", l, 1, 0, 0, 0, 8'h00, 4'b0001); tick(); end
        for (int d = 0; d < 3; d++) begin
            for (int l = 0; l < NL; l++) byte_in[l*8 +: 8] = (8'h35 + 8'(d) * 8'h4c) ^ (8'(l) * 8'h11);
            if (d == 2) hs_req = 1'b0;
            #1;
            for (int l = 0; l < NL; l++) begin
                lastb[l] = order(byte_in[l*8 +: 8], c[0]);
                chk_lane("R4/R10 payload", l, 1, 0, 0, 0, lastb[l], 4'b0001);
            end
            tick();
        end
        repeat (eff(c[16:9]))
            begin for (int l = 0; l < NL; l++) chk_lane("R5 trailer", l, 1, 0, 0, 0, {8{~lastb[l][7]}}, 4'b0001); tick(); end
        hs_req = 1'b1;
        repeat (eff(c[8:1])) begin chk_all_stop("R5 exit ignores request"); tick(); end
        chk_all_stop("R5 back in stop");
        hs_req = 1'b0;
        tick();
        chk_all_stop("R1 idle stop");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        chk_all_stop("R1 reset state");

        for (int t = 0; t < 4; t++) run_burst(CFG_TAB[t]);

        // Override mux in stop (R7)
        ovr_hs_sel = 4'b0010; ovr_hs_val = 4'b0010;
        ovr_lp_sel = 4'b0010; ovr_lp_val = 4'b0000;
        #1;
        chk_lane("R7 override lane1", 1, 1, 0, 1, 1, 8'h00, 4'b0100);
        chk_lane("R7 other lane intact", 0, 0, 1, 1, 1, 8'h00, 4'b0100);
        ovr_hs_sel = '0; ovr_hs_val = '0; ovr_lp_sel = '0;
        tick();

        // Override mid-payload, then force stop (R7, R6)
        req_cnt = 8'd1; hs_timing = 32'h01010202; msb_first = 1'b0;
        byte_in = 32'hA5A5A5A5;
        hs_req = 1'b1;
        repeat (4) tick();
        chk_lane("R4 in payload", 0, 1, 0, 0, 0, 8'hA5, 4'b0001);
        ovr_hs_sel = 4'b0001; ovr_hs_val = 4'b0000;
        #1;
        chk_lane("R7 override mid-payload", 0, 0, 0, 0, 0, 8'hA5, 4'b0001);
        ovr_hs_sel = '0;
        force_stop = 1'b1;
        tick();
        chk_all_stop("R6 force stop entry");
        repeat (2) begin tick(); chk_all_stop("R6 force stop hold"); end
        force_stop = 1'b0;
        tick();
        chk_lane("R6 request after release", 0, 0, 1, 0, 1, 8'h00, 4'b0000);
        hs_req = 1'b0;
        repeat (12) tick();
        chk_all_stop("R6 sequence completes");

        // Power-down of one lane (R8, R10)
        lane_pd = 4'b0100;
        tick();
        chk_lane("R8 lane off", 2, 0, 0, 0, 0, 8'h00, 4'b0000);
        hs_req = 1'b1;
        tick();
        chk_lane("R8 lane off with request", 2, 0, 0, 0, 0, 8'h00, 4'b0000);
        chk_lane("R10 neighbour runs", 0, 0, 1, 0, 1, 8'h00, 4'b0000);
        hs_req = 1'b0;
        repeat (16) tick();
        lane_pd = '0;
        tick();
        chk_all_stop("R8 lane resumes in stop");

        // Reset during a burst (R1)
        hs_req = 1'b1;
        repeat (3) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        hs_req = 1'b0;
        tick();
        chk_all_stop("R1 reset mid-burst");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule